// File: doc/BRIEF.md
# Multiplexed address/data bus controller

This block is an external bus master for one chip-select area whose address and data share the same pins. A request on the internal side carries an address, write data, a read/write flag and a one-cycle start strobe. The block then runs one bus access on the upper pins of a 32-bit external data bus. It first places the address on those pins with an address latch enable pulse. It then turns the pins around and asserts a read or write strobe for a programmable number of cycles. Chip select is held low for the whole access.

A small mode register sets three things: whether multiplexed operation is enabled, the bus width (8 or 16 bits) and the number of automatically inserted wait cycles (0 to 7). The register is written through three field inputs and a write enable. A request made while the register holds an unusable setting is refused with a one-cycle error pulse, and no bus activity follows. A completed access returns a one-cycle done pulse. A read also returns its data, zero-extended to the internal port width.

All bus outputs are registered. The external data pins are modelled as an output vector, a single output enable and the input value of the upper 16 pins.

Top module: `muxbus_master`

## Requirements
- R1: After synchronous reset, bus_cs_n, bus_rd_n and bus_wr_n are 1, while bus_ale, bus_d_oe, rsp_done and rsp_err are 0. The mode register resets to multiplex disabled, width code 00 and a wait count of 0.
- R2: When cfg_we is high at a clock edge, the mode register loads cfg_mux_en, cfg_width and cfg_wait. Width code 00 means 8 bits, 01 means 16 bits, and 10 and 11 are reserved.
- R3: A start seen while idle, with multiplex disabled or a reserved width code, makes rsp_err 1 for exactly the following cycle. In that case bus_cs_n stays 1, bus_ale stays 0 and rsp_done stays 0.
- R4: In the cycle after an accepted start, bus_ale is 1, bus_cs_n is 0 and bus_d_oe is 1. At 8-bit width, bus_d_out[31:24] carries address bits 7..0 and the other pins are 0. At 16-bit width, bus_d_out[31:16] carries address bits 15..0 and bus_d_out[15:0] is 0. bus_ale is high for one cycle only.
- R5: The next cycle is a turnaround cycle. bus_ale is 0, both strobes are 1 and bus_cs_n is 0. A write drives its data with bus_d_oe at 1. A read sets bus_d_oe to 0 and bus_d_out to 0.
- R6: The strobe (bus_rd_n for a read, bus_wr_n for a write) is 0 for exactly 1 + wait-count cycles, while bus_cs_n is 0. The two strobes are never 0 together.
- R7: Write data uses the same pins as the address: data bits 7..0 go on pins 31..24 at 8-bit width, and data bits 15..0 go on pins 31..16 at 16-bit width. This value is held unchanged from the turnaround cycle through the last strobe cycle.
- R8: A read captures bus_d_in on the last strobe cycle. At 16-bit width rsp_rdata equals that value. At 8-bit width rsp_rdata is {8'h00, bus_d_in[15:8]}, which are the bits seen on pins 31..24.
- R9: rsp_done is 1 for exactly the one cycle after the last strobe cycle. In that cycle bus_cs_n is 1, both strobes are 1 and bus_d_oe is 0. A start given in the done cycle is accepted, so bus_cs_n is high for exactly one cycle between two accesses.
- R10: A start given while an access is running is ignored. The running access keeps its address, its data and its length, and no second access follows it.
- R11: The width and wait count are taken when a start is accepted. A mode register write during an access does not change that access, but it does apply to the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Mode register write enable |
| cfg_mux_en | input | 1 | Multiplex enable field to write (must be 1 for operation) |
| cfg_width | input | 2 | Bus width code to write: 00 = 8 bits, 01 = 16 bits |
| cfg_wait | input | 3 | Wait-cycle count to write |
| req_start | input | 1 | Start strobe for one access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Read data, zero-extended at 8-bit width |
| rsp_done | output | 1 | One-cycle pulse when an access completes |
| rsp_err | output | 1 | One-cycle pulse when a start is refused |
| bus_d_out | output | 32 | Value driven on the shared address/data pins |
| bus_d_oe | output | 1 | Output enable for the data pins |
| bus_d_in | input | 16 | Value seen on data pins 31..16 |
| bus_ale | output | 1 | Address latch enable, active high |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |

## Verification
The hardest behaviour to pin down from the ports is when the read data is sampled. If the pins hold one value for the whole strobe, the result does not show whether the capture happened on the first strobe cycle or the last. The bench therefore drives a different value onto bus_d_in in every strobe cycle, and expects only the value from the final cycle. A second hard case is a change of mode, or a new start, while an access is running. The bench issues a start with a different address and a mode write with a larger wait count during the address cycle. It then checks the running access cycle by cycle, and checks that the next access uses the new wait count.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ADDR = 2'd1,
    SQ_TURN = 2'd2,
    SQ_STRB = 2'd3
  } sq_state_e;

  localparam logic [1:0] BUSW_8  = 2'b00;
  localparam logic [1:0] BUSW_16 = 2'b01;
  localparam int         LANE_W  = 8;
endpackage

// File: rtl/muxbus_mode_reg.sv
module muxbus_mode_reg
  import muxbus_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_mux_en,
  input  logic [1:0]        cfg_width,
  input  logic [WAIT_W-1:0] cfg_wait,
  output logic              wide,
  output logic [WAIT_W-1:0] wait_n,
  output logic              cfg_ok
);
  logic       mux_q;
  logic [1:0] width_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mux_q   <= 1'b0;
      width_q <= BUSW_8;
      wait_n  <= '0;
    end else if (cfg_we) begin
      mux_q   <= cfg_mux_en;
      width_q <= cfg_width;
      wait_n  <= cfg_wait;
    end
  end

  assign wide   = (width_q == BUSW_16);
  assign cfg_ok = mux_q && ((width_q == BUSW_8) || (width_q == BUSW_16));

  // R2: a written code that is neither 8 nor 16 bits never yields a usable mode
  a_r2_reserved_refused: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_width[1]) |=> !cfg_ok);
endmodule

// File: rtl/muxbus_seq.sv
module muxbus_seq
  import muxbus_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cfg_ok,
  input  logic [WAIT_W-1:0] wait_n,
  output sq_state_e         state_q,
  output sq_state_e         state_d,
  output logic              accept,
  output logic              reject,
  output logic              last_strb
);
  logic [WAIT_W-1:0] wait_q;
  logic [WAIT_W-1:0] cnt_q;

  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    reject  = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (start) begin
          if (cfg_ok) begin
            accept  = 1'b1;
            state_d = SQ_ADDR;
          end else begin
            reject = 1'b1;
          end
        end
      end
      SQ_ADDR: state_d = SQ_TURN;
      SQ_TURN: state_d = SQ_STRB;
      SQ_STRB: if (cnt_q == '0) state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  assign last_strb = (state_q == SQ_STRB) && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      wait_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) wait_q <= wait_n;
      if (state_q == SQ_TURN)
        cnt_q <= wait_q;
      else if ((state_q == SQ_STRB) && (cnt_q != '0))
        cnt_q <= cnt_q - 1'b1;
    end
  end

  // R6: the strobe countdown never exceeds the count taken at acceptance
  a_r6_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    (state_q == SQ_STRB) |-> (cnt_q <= wait_q));

  // R11: the wait count of a running access is frozen
  a_r11_wait_frozen: assert property (@(posedge clk) disable iff (rst)
    ((state_q != SQ_IDLE) && ($past(state_q) != SQ_IDLE)) |-> $stable(wait_q));

  // R10: no new start is taken while an access is running
  a_r10_busy_no_accept: assert property (@(posedge clk) disable iff (rst)
    (state_q != SQ_IDLE) |=> (state_q != SQ_ADDR));
endmodule

// File: rtl/muxbus_lanes.sv
module muxbus_lanes
  import muxbus_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int BUS_W  = 32
) (
  input  logic              wide,
  input  logic [PORT_W-1:0] addr,
  input  logic [PORT_W-1:0] wdata,
  input  logic [PORT_W-1:0] d_hi,
  output logic [BUS_W-1:0]  addr_img,
  output logic [BUS_W-1:0]  data_img,
  output logic [PORT_W-1:0] rd_word
);
  localparam int N_LANES = PORT_W / LANE_W;
  localparam int LOW_W   = BUS_W - PORT_W;

  for (genvar i = 0; i < N_LANES; i++) begin : g_out_lane
    localparam int HI  = BUS_W - 1 - i * LANE_W;
    localparam int SRC = (N_LANES - 1 - i) * LANE_W;
    if (i == 0) begin : g_top
      assign addr_img[HI -: LANE_W] = wide ? addr[SRC +: LANE_W]  : addr[LANE_W-1:0];
      assign data_img[HI -: LANE_W] = wide ? wdata[SRC +: LANE_W] : wdata[LANE_W-1:0];
    end else begin : g_rest
      assign addr_img[HI -: LANE_W] = wide ? addr[SRC +: LANE_W]  : '0;
      assign data_img[HI -: LANE_W] = wide ? wdata[SRC +: LANE_W] : '0;
    end
  end

  if (LOW_W > 0) begin : g_low
    assign addr_img[LOW_W-1:0] = '0;
    assign data_img[LOW_W-1:0] = '0;
  end

  for (genvar j = 0; j < N_LANES; j++) begin : g_in_lane
    if (j == 0) begin : g_lsb
      assign rd_word[LANE_W-1:0] = wide ? d_hi[LANE_W-1:0] : d_hi[PORT_W-1 -: LANE_W];
    end else begin : g_msb
      assign rd_word[j*LANE_W +: LANE_W] = wide ? d_hi[j*LANE_W +: LANE_W] : '0;
    end
  end
endmodule

// File: rtl/muxbus_master.sv
module muxbus_master
  import muxbus_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int BUS_W  = 32,
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_mux_en,
  input  logic [1:0]        cfg_width,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              req_start,
  input  logic              req_write,
  input  logic [PORT_W-1:0] req_addr,
  input  logic [PORT_W-1:0] req_wdata,
  output logic [PORT_W-1:0] rsp_rdata,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [BUS_W-1:0]  bus_d_out,
  output logic              bus_d_oe,
  input  logic [PORT_W-1:0] bus_d_in,
  output logic              bus_ale,
  output logic              bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_wr_n
);
  logic              cfg_wide;
  logic [WAIT_W-1:0] cfg_wait_q;
  logic              cfg_ok;
  sq_state_e         state_q;
  sq_state_e         state_d;
  logic              accept;
  logic              reject;
  logic              last_strb;

  logic              wr_q;
  logic              wide_q;
  logic [PORT_W-1:0] addr_q;
  logic [PORT_W-1:0] wdata_q;

  logic              wide_src;
  logic [PORT_W-1:0] addr_src;
  logic [BUS_W-1:0]  addr_img;
  logic [BUS_W-1:0]  data_img;
  logic [PORT_W-1:0] rd_word;

  muxbus_mode_reg #(.WAIT_W(WAIT_W)) u_mode (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_mux_en(cfg_mux_en),
    .cfg_width (cfg_width),
    .cfg_wait  (cfg_wait),
    .wide      (cfg_wide),
    .wait_n    (cfg_wait_q),
    .cfg_ok    (cfg_ok)
  );

  muxbus_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (req_start),
    .cfg_ok   (cfg_ok),
    .wait_n   (cfg_wait_q),
    .state_q  (state_q),
    .state_d  (state_d),
    .accept   (accept),
    .reject   (reject),
    .last_strb(last_strb)
  );

  // the address image is built from the request itself in the accepting cycle
  assign wide_src = accept ? cfg_wide : wide_q;
  assign addr_src = accept ? req_addr : addr_q;

  muxbus_lanes #(.PORT_W(PORT_W), .BUS_W(BUS_W)) u_lanes (
    .wide    (wide_src),
    .addr    (addr_src),
    .wdata   (wdata_q),
    .d_hi    (bus_d_in),
    .addr_img(addr_img),
    .data_img(data_img),
    .rd_word (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q    <= 1'b0;
      wide_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      wide_q  <= cfg_wide;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_cs_n  <= 1'b1;
      bus_ale   <= 1'b0;
      bus_rd_n  <= 1'b1;
      bus_wr_n  <= 1'b1;
      bus_d_oe  <= 1'b0;
      bus_d_out <= '0;
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_err  <= reject;
      rsp_done <= last_strb;
      if (last_strb && !wr_q) rsp_rdata <= rd_word;
      case (state_d)
        SQ_ADDR: begin
          bus_cs_n  <= 1'b0;
          bus_ale   <= 1'b1;
          bus_rd_n  <= 1'b1;
          bus_wr_n  <= 1'b1;
          bus_d_oe  <= 1'b1;
          bus_d_out <= addr_img;
        end
        SQ_TURN: begin
          bus_cs_n  <= 1'b0;
          bus_ale   <= 1'b0;
          bus_rd_n  <= 1'b1;
          bus_wr_n  <= 1'b1;
          bus_d_oe  <= wr_q;
          bus_d_out <= wr_q ? data_img : '0;
        end
        SQ_STRB: begin
          bus_cs_n  <= 1'b0;
          bus_ale   <= 1'b0;
          bus_rd_n  <= wr_q;
          bus_wr_n  <= !wr_q;
        end
        default: begin
          bus_cs_n  <= 1'b1;
          bus_ale   <= 1'b0;
          bus_rd_n  <= 1'b1;
          bus_wr_n  <= 1'b1;
          bus_d_oe  <= 1'b0;
          bus_d_out <= '0;
        end
      endcase
    end
  end

  // R4: address latch enable is a single-cycle pulse inside chip select
  a_r4_ale_single: assert property (@(posedge clk) disable iff (rst)
    bus_ale |=> !bus_ale);
  a_r4_ale_in_cs: assert property (@(posedge clk) disable iff (rst)
    bus_ale |-> (!bus_cs_n && bus_d_oe && bus_rd_n && bus_wr_n));

  // R5: the cycle after the address phase is a strobe-free turnaround
  a_r5_turnaround: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_ale) |-> (bus_rd_n && bus_wr_n && !bus_cs_n));

  // R6: never both strobes, and strobes only under chip select
  a_r6_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(!bus_rd_n && !bus_wr_n));
  a_r6_strobe_in_cs: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd_n || !bus_wr_n) |-> (!bus_cs_n && !bus_ale));

  // R7: write data stays still while the write strobe is active
  a_r7_write_hold: assert property (@(posedge clk) disable iff (rst)
    (!bus_wr_n && $past(!bus_wr_n)) |-> $stable(bus_d_out));

  // R8: the pins are released during a read strobe
  a_r8_read_released: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_n |-> !bus_d_oe);

  // R9: completion is a single pulse with the bus idle
  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> (bus_cs_n && bus_rd_n && bus_wr_n && !bus_d_oe));
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // R3: a refused start produces no bus cycle
  a_r3_err_quiet: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (bus_cs_n && !bus_ale && !rsp_done));
endmodule

// File: tb/tb_muxbus_master.sv
module tb_muxbus_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_mux_en = 1'b0;
  logic [1:0]  cfg_width = 2'b00;
  logic [2:0]  cfg_wait = 3'd0;
  logic        req_start = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [15:0] rsp_rdata;
  logic        rsp_done;
  logic        rsp_err;
  logic [31:0] bus_d_out;
  logic        bus_d_oe;
  logic [15:0] bus_d_in = '0;
  logic        bus_ale;
  logic        bus_cs_n;
  logic        bus_rd_n;
  logic        bus_wr_n;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  bit          ch_wr;
  logic [15:0] ch_addr;
  logic [15:0] ch_data;

  muxbus_master dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mux_en(cfg_mux_en),
    .cfg_width(cfg_width), .cfg_wait(cfg_wait), .req_start(req_start),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe), .bus_d_in(bus_d_in),
    .bus_ale(bus_ale), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input bit m, input logic [1:0] w, input logic [2:0] n);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mux_en = m; cfg_width = w; cfg_wait = n;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 cs_n", bus_cs_n, 1);
    chk("R1 ale", bus_ale, 0);
    chk("R1 rd_n", bus_rd_n, 1);
    chk("R1 wr_n", bus_wr_n, 1);
    chk("R1 oe", bus_d_oe, 0);
    chk("R1 done", rsp_done, 0);
    chk("R1 err", rsp_err, 0);
  endtask

  task automatic t_reject(input string tag);
    @(negedge clk);
    req_start = 1'b1; req_write = 1'b0; req_addr = 16'h1234;
    @(negedge clk);
    req_start = 1'b0;
    chk({tag, " R3 err"}, rsp_err, 1);
    chk({tag, " R3 cs_n"}, bus_cs_n, 1);
    chk({tag, " R3 ale"}, bus_ale, 0);
    chk({tag, " R3 done"}, rsp_done, 0);
    @(negedge clk);
    chk({tag, " R3 err pulse"}, rsp_err, 0);
    chk({tag, " R3 cs_n after"}, bus_cs_n, 1);
  endtask

  // One access, checked cycle by cycle. pre: start already driven.
  // poke: start and mode write while busy. chain: start next access in done cycle.
  task automatic run_acc(input string tag, input bit wr, input logic [15:0] a,
                         input logic [15:0] wd, input bit wide, input int w,
                         input logic [15:0] base, input bit pre, input bit poke,
                         input bit chain);
    logic [31:0] ea, ed;
    logic [15:0] v, er;
    ea = wide ? {a, 16'h0000} : {a[7:0], 24'h000000};
    ed = wide ? {wd, 16'h0000} : {wd[7:0], 24'h000000};
    v  = '0;
    if (!pre) begin
      @(negedge clk);
      req_start = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    end
    @(negedge clk);
    req_start = poke;
    if (poke) begin
      req_addr = ~a; req_wdata = ~wd; req_write = !wr;
      cfg_we = 1'b1; cfg_wait = 3'd7;
    end
    chk({tag, " R4 ale"}, bus_ale, 1);
    chk({tag, " R4 cs_n"}, bus_cs_n, 0);
    chk({tag, " R4 oe"}, bus_d_oe, 1);
    chk({tag, " R4 addr lanes"}, bus_d_out, ea);
    @(negedge clk);
    req_start = 1'b0; cfg_we = 1'b0;
    chk({tag, " R5 ale low"}, bus_ale, 0);
    chk({tag, " R5 cs_n"}, bus_cs_n, 0);
    chk({tag, " R5 strobes idle"}, {bus_rd_n, bus_wr_n}, 2'b11);
    chk({tag, " R5 oe"}, bus_d_oe, wr);
    chk({tag, " R7 turn data"}, bus_d_out, wr ? ed : 32'h0);
    for (int k = 0; k <= w; k++) begin
      @(negedge clk);
      v = base + 16'(k) * 16'h1357;
      bus_d_in = v;
      chk({tag, " R6 rd_n"}, bus_rd_n, wr);
      chk({tag, " R6 wr_n"}, bus_wr_n, !wr);
      chk({tag, " R6 cs_n"}, bus_cs_n, 0);
      if (wr) chk({tag, " R7 data held"}, bus_d_out, ed);
      else    chk({tag, " R8 released"}, bus_d_oe, 0);
    end
    @(negedge clk);
    er = wide ? v : {8'h00, v[15:8]};
    chk({tag, " R6 strobe end / R9 done"}, rsp_done, 1);
    chk({tag, " R9 cs_n gap"}, bus_cs_n, 1);
    chk({tag, " R9 strobes"}, {bus_rd_n, bus_wr_n}, 2'b11);
    chk({tag, " R9 oe"}, bus_d_oe, 0);
    if (!wr) chk({tag, " R8 rdata"}, rsp_rdata, er);
    if (chain) begin
      req_start = 1'b1; req_write = ch_wr; req_addr = ch_addr; req_wdata = ch_data;
    end else begin
      @(negedge clk);
      chk({tag, " R9 done pulse"}, rsp_done, 0);
      chk({tag, " R10 no extra ale"}, bus_ale, 0);
      chk({tag, " R10 no extra cs"}, bus_cs_n, 1);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc >= 20000) begin
        bad++; total++;
        $display("FAIL watchdog act=%0d exp=<20000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    // R2/R3: reset mode has multiplex disabled
    t_reject("reset-mode");
    // 8-bit, no wait
    set_cfg(1'b1, 2'b00, 3'd0);
    run_acc("w8", 1'b1, 16'hA5C3, 16'h7E81, 1'b0, 0, 16'h0000, 1'b0, 1'b0, 1'b0);
    run_acc("r8", 1'b0, 16'h1F2E, 16'h0000, 1'b0, 0, 16'hB4C7, 1'b0, 1'b0, 1'b0);
    // 16-bit, two waits
    set_cfg(1'b1, 2'b01, 3'd2);
    run_acc("w16", 1'b1, 16'hBEEF, 16'h4321, 1'b1, 2, 16'h0000, 1'b0, 1'b0, 1'b0);
    run_acc("r16", 1'b0, 16'h8001, 16'h0000, 1'b1, 2, 16'h2468, 1'b0, 1'b0, 1'b0);
    // R10 R11: busy start and mode write during a 16-bit read with wait 5
    set_cfg(1'b1, 2'b01, 3'd5);
    cfg_mux_en = 1'b1; cfg_width = 2'b01;
    run_acc("r16poke", 1'b0, 16'h5A5A, 16'h0000, 1'b1, 5, 16'h9100, 1'b0, 1'b1, 1'b0);
    run_acc("r16w7 R11", 1'b0, 16'h0F0F, 16'h0000, 1'b1, 7, 16'h3C00, 1'b0, 1'b0, 1'b0);
    // R3: reserved widths and disabled multiplex
    set_cfg(1'b1, 2'b10, 3'd1);
    t_reject("bw10");
    set_cfg(1'b1, 2'b11, 3'd1);
    t_reject("bw11");
    set_cfg(1'b0, 2'b01, 3'd1);
    t_reject("mux0");
    // R9: back-to-back, second start in the done cycle
    set_cfg(1'b1, 2'b00, 3'd1);
    ch_wr = 1'b0; ch_addr = 16'h00C6; ch_data = 16'h0000;
    run_acc("b2b-1", 1'b1, 16'h0033, 16'h00E4, 1'b0, 1, 16'h0000, 1'b0, 1'b0, 1'b1);
    run_acc("b2b-2 R9", 1'b0, 16'h00C6, 16'h0000, 1'b0, 1, 16'hD21F, 1'b1, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule